// File: doc/BRIEF.md
# Sound-CPU Address Decoder with Host Mailboxes

This block is the glue logic of a small sound subsystem. An 8-bit sound CPU with a 16-bit address bus runs a fixed memory map. The block decodes each CPU read or write into one select for one of these targets: the program ROM, a 0x900-byte work RAM that is reached through two windows, one FM synthesis chip, or one of two ADPCM sample chips. The memories and chips sit outside the block. The block drives their select, write-enable and address lines, and it multiplexes their read data back onto the CPU bus.

Two 8-bit mailbox latches carry bytes between the host processor and the sound CPU, one latch for each direction. Two bank registers page the upper half of each ADPCM chip's 18-bit sample space across a larger sample ROM. The stored bank value is offset by one before it is used, so the value 0 left by reset selects page 1. The host sets the sound CPU's NMI level through an inverted control bit. The FM chip's interrupt goes straight to the CPU's IRQ input.

Top module: `snd_glue_top`

## Requirements
- R1: Reads in 0x0000–0xEFFF assert `rom_cs` and return `rom_rdata`. Writes to that range assert no select at all.
- R2: Accesses in 0xF000–0xF7FF assert `ram_cs` with `ram_addr` = address − 0xF000. `ram_we` follows the write strobe, and reads return `ram_rdata`.
- R3: Accesses in 0xFEC0–0xFFBF assert `ram_cs` with `ram_addr` = 0x800 + (address − 0xFEC0). Address 0xFFC0 is outside the window.
- R4: Accesses to 0xF800 or 0xF801 assert `fm_cs`, with `fm_a0` equal to address bit 0. `fm_we` follows the write strobe, and reads return `fm_rdata`.
- R5: Address 0xF900 asserts `adp_cs[0]` and address 0xFA00 asserts `adp_cs[1]`, for reads and for writes. Reads return that chip's data.
- R6: A `host_wr` pulse loads `host_wdata` into the host-to-sound latch. A CPU read of 0xFB00 returns that latch.
- R7: A CPU write to 0xFC00 loads the sound-to-host latch. The latch appears on `host_rdata` after the clock edge.
- R8: CPU writes to 0xFC01 and 0xFC02 store the raw byte in bank register 0 and bank register 1. The stored bytes appear on `bank_raw0` and `bank_raw1`.
- R9: A sample address below 0x20000 maps to the same ROM address. A sample address A of 0x20000 or above maps to 0x20000 + ((raw+1) & 3) × 0x20000 + (A − 0x20000).
- R10: Reset clears both latches and both bank registers, so sample address 0x20000 maps to 0x40000. Reset also deasserts `cpu_nmi`.
- R11: A `host_nmi_wr` pulse captures `host_nmi_bit`. `cpu_nmi` is then held at the inverse of the captured bit.
- R12: `cpu_irq` equals `fm_irq` in every cycle.
- R13: Reads of unmapped addresses return 0x00, writes to unmapped addresses change no state, and at most one select is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Sound-CPU address |
| cpu_rd | input | 1 | Sound-CPU read strobe |
| cpu_wr | input | 1 | Sound-CPU write strobe |
| cpu_wdata | input | 8 | Sound-CPU write data |
| cpu_rdata | output | 8 | Read data returned to the sound CPU |
| rom_cs | output | 1 | Program ROM select |
| rom_rdata | input | 8 | Program ROM data |
| ram_cs | output | 1 | Work RAM select |
| ram_we | output | 1 | Work RAM write enable |
| ram_addr | output | 12 | Work RAM offset |
| ram_rdata | input | 8 | Work RAM data |
| fm_cs | output | 1 | FM chip select |
| fm_we | output | 1 | FM chip write enable |
| fm_a0 | output | 1 | FM register/data select |
| fm_rdata | input | 8 | FM chip data |
| fm_irq | input | 1 | FM chip interrupt request |
| adp_cs | output | 2 | ADPCM chip selects |
| adp_we | output | 1 | ADPCM write enable |
| adp_rdata0 | input | 8 | ADPCM chip 0 data |
| adp_rdata1 | input | 8 | ADPCM chip 1 data |
| adp_smp0 | input | 18 | ADPCM chip 0 sample address |
| adp_smp1 | input | 18 | ADPCM chip 1 sample address |
| adp_rom0 | output | 20 | Banked ROM address for chip 0 |
| adp_rom1 | output | 20 | Banked ROM address for chip 1 |
| bank_raw0 | output | 8 | Stored bank byte for chip 0 |
| bank_raw1 | output | 8 | Stored bank byte for chip 1 |
| host_wr | input | 1 | Host mailbox write strobe |
| host_wdata | input | 8 | Host mailbox data |
| host_rdata | output | 8 | Sound-to-host latch |
| host_nmi_wr | input | 1 | Host NMI control write strobe |
| host_nmi_bit | input | 1 | Host NMI control bit (active low) |
| cpu_nmi | output | 1 | Sound-CPU NMI level |
| cpu_irq | output | 1 | Sound-CPU IRQ level |

## Verification
The bench probes the edges of every window: 0xEFFF against 0xF000, 0xF7FF, 0xFEC0, 0xFFBF and the first excluded address 0xFFC0. An off-by-one comparison would either leave a hole in the map or let two selects fire together. It writes the bank values 0, 2, 3 and 0xFF. A design that drops the +1 offset, or forgets to wrap it modulo 4, then maps the upper sample half to the wrong page, and an error in the lower-half bypass shows at 0x1ABCD. It writes to 0xFC03 and to a ROM address and then reads the latches and bank registers back, to catch a loose decode. It also drives the NMI control bit both ways, to catch a missing inversion.

// File: rtl/snd_glue_pkg.sv
package snd_glue_pkg;

  localparam int ADDR_W = 16;

  localparam logic [15:0] ROM_LAST    = 16'hEFFF;
  localparam logic [15:0] RAM_LO_BASE = 16'hF000;
  localparam logic [15:0] RAM_LO_LAST = 16'hF7FF;
  localparam logic [15:0] RAM_HI_BASE = 16'hFEC0;
  localparam logic [15:0] RAM_HI_LAST = 16'hFFBF;
  localparam logic [15:0] RAM_HI_OFS  = 16'h0800;
  localparam logic [15:0] FM_REG      = 16'hF800;
  localparam logic [15:0] FM_DAT      = 16'hF801;
  localparam logic [15:0] ADP0_PORT   = 16'hF900;
  localparam logic [15:0] ADP1_PORT   = 16'hFA00;
  localparam logic [15:0] H2S_PORT    = 16'hFB00;
  localparam logic [15:0] S2H_PORT    = 16'hFC00;
  localparam logic [15:0] BANK0_PORT  = 16'hFC01;
  localparam logic [15:0] BANK1_PORT  = 16'hFC02;

  typedef enum logic [3:0] {
    RG_NONE, RG_ROM, RG_RAM_LO, RG_RAM_HI, RG_FM, RG_ADP0, RG_ADP1,
    RG_H2S_RD, RG_S2H_WR, RG_BANK0_WR, RG_BANK1_WR
  } region_e;

  // Classifies one bus access. Read-only and write-only ports match only their own strobe.
  function automatic region_e decode_region(input logic [15:0] a, input logic rd, input logic wr);
    region_e r;
    r = RG_NONE;
    if (rd || wr) begin
      if (a <= ROM_LAST)                              r = rd ? RG_ROM : RG_NONE;
      else if (a >= RAM_LO_BASE && a <= RAM_LO_LAST)  r = RG_RAM_LO;
      else if (a >= RAM_HI_BASE && a <= RAM_HI_LAST)  r = RG_RAM_HI;
      else begin
        case (a)
          FM_REG, FM_DAT: r = RG_FM;
          ADP0_PORT:      r = RG_ADP0;
          ADP1_PORT:      r = RG_ADP1;
          H2S_PORT:       r = rd ? RG_H2S_RD : RG_NONE;
          S2H_PORT:       r = wr ? RG_S2H_WR : RG_NONE;
          BANK0_PORT:     r = wr ? RG_BANK0_WR : RG_NONE;
          BANK1_PORT:     r = wr ? RG_BANK1_WR : RG_NONE;
          default:        r = RG_NONE;
        endcase
      end
    end
    return r;
  endfunction

  // Flat RAM offset for either window.
  function automatic logic [15:0] ram_offset(input logic [15:0] a, input logic hi_win);
    return hi_win ? (RAM_HI_OFS + (a - RAM_HI_BASE)) : (a - RAM_LO_BASE);
  endfunction

endpackage

// File: rtl/snd_addr_decode.sv
module snd_addr_decode
  import snd_glue_pkg::*;
#(
  parameter int RAM_AW  = 12,
  parameter int NUM_ADP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       addr,
  input  logic              rd,
  input  logic              wr,
  output region_e           region,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              fm_cs,
  output logic              fm_we,
  output logic              fm_a0,
  output logic [NUM_ADP-1:0] adp_cs,
  output logic              adp_we,
  output logic              h2s_rd,
  output logic              s2h_ld,
  output logic [NUM_ADP-1:0] bank_ld
);

  logic [15:0] ofs_full;

  always_comb begin
    region   = decode_region(addr, rd, wr);
    ofs_full = ram_offset(addr, region == RG_RAM_HI);
    rom_cs   = (region == RG_ROM);
    ram_cs   = (region == RG_RAM_LO) || (region == RG_RAM_HI);
    ram_we   = ram_cs && wr;
    ram_addr = ram_cs ? ofs_full[RAM_AW-1:0] : '0;
    fm_cs    = (region == RG_FM);
    fm_we    = fm_cs && wr;
    fm_a0    = fm_cs && addr[0];
    adp_cs   = '0;
    adp_cs[0] = (region == RG_ADP0);
    adp_cs[1] = (region == RG_ADP1);
    adp_we   = (|adp_cs) && wr;
    h2s_rd   = (region == RG_H2S_RD);
    s2h_ld   = (region == RG_S2H_WR);
    bank_ld  = '0;
    bank_ld[0] = (region == RG_BANK0_WR);
    bank_ld[1] = (region == RG_BANK1_WR);
  end

  p_one_select_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs, fm_cs, adp_cs, h2s_rd, s2h_ld, bank_ld}));

  p_rom_read_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> !rom_cs);

  p_ram_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> (ram_addr < RAM_AW'(12'h900)));

endmodule

// File: rtl/snd_mailbox.sv
module snd_mailbox #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              cpu_ld,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] h2s_q,
  output logic [DATA_W-1:0] s2h_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h2s_q <= '0;
      s2h_q <= '0;
    end else begin
      if (host_wr) h2s_q <= host_wdata;
      if (cpu_ld)  s2h_q <= cpu_wdata;
    end
  end

  p_h2s_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (h2s_q == $past(host_wdata)));

  p_s2h_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ld |=> (s2h_q == $past(cpu_wdata)));

  p_s2h_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ld |=> $stable(s2h_q));

endmodule

// File: rtl/snd_bank_map.sv
module snd_bank_map #(
  parameter int DATA_W = 8,
  parameter int SMP_AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SMP_AW-1:0] smp_addr,
  output logic [DATA_W-1:0] raw_q,
  output logic [SMP_AW+1:0] rom_addr
);

  localparam int HALF_AW = SMP_AW - 1;
  localparam int ROM_AW  = SMP_AW + 2;

  // The stored byte is offset by one and wrapped to four pages. The upper half
  // of the sample space then lands on ROM page (eff + 1).
  function automatic logic [1:0] eff_bank(input logic [DATA_W-1:0] raw);
    return raw[1:0] + 2'd1;
  endfunction

  function automatic logic [ROM_AW-1:0] map_sample(input logic [SMP_AW-1:0] a,
                                                   input logic [DATA_W-1:0] raw);
    logic [2:0] page;
    if (!a[SMP_AW-1]) return ROM_AW'(a);
    page = {1'b0, eff_bank(raw)} + 3'd1;
    return {page, a[HALF_AW-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else if (ld) raw_q <= wdata;
  end

  assign rom_addr = map_sample(smp_addr, raw_q);

  p_bank_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (raw_q == $past(wdata)));

  p_low_half_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_addr[SMP_AW-1] |-> (rom_addr == ROM_AW'(smp_addr)));

  p_high_half_paged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_addr[SMP_AW-1] |-> (rom_addr[ROM_AW-1:HALF_AW] != 3'd0));

endmodule

// File: rtl/snd_glue_top.sv
module snd_glue_top
  import snd_glue_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RAM_AW  = 12,
  parameter int SMP_AW  = 18,
  parameter int NUM_ADP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              rom_cs,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              fm_cs,
  output logic              fm_we,
  output logic              fm_a0,
  input  logic [DATA_W-1:0] fm_rdata,
  input  logic              fm_irq,
  output logic [NUM_ADP-1:0] adp_cs,
  output logic              adp_we,
  input  logic [DATA_W-1:0] adp_rdata0,
  input  logic [DATA_W-1:0] adp_rdata1,
  input  logic [SMP_AW-1:0] adp_smp0,
  input  logic [SMP_AW-1:0] adp_smp1,
  output logic [SMP_AW+1:0] adp_rom0,
  output logic [SMP_AW+1:0] adp_rom1,
  output logic [DATA_W-1:0] bank_raw0,
  output logic [DATA_W-1:0] bank_raw1,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              host_nmi_wr,
  input  logic              host_nmi_bit,
  output logic              cpu_nmi,
  output logic              cpu_irq
);

  localparam int ROM_AW = SMP_AW + 2;

  region_e                   region;
  logic                      h2s_rd;
  logic                      s2h_ld;
  logic [NUM_ADP-1:0]        bank_ld;
  logic [DATA_W-1:0]         h2s_q;
  logic [NUM_ADP-1:0][SMP_AW-1:0] smp_vec;
  logic [NUM_ADP-1:0][ROM_AW-1:0] rom_vec;
  logic [NUM_ADP-1:0][DATA_W-1:0] raw_vec;
  logic [NUM_ADP-1:0][DATA_W-1:0] adp_rd_vec;
  logic                      nmi_q;

  snd_addr_decode #(.RAM_AW(RAM_AW), .NUM_ADP(NUM_ADP)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .region(region), .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_addr(ram_addr), .fm_cs(fm_cs), .fm_we(fm_we), .fm_a0(fm_a0),
    .adp_cs(adp_cs), .adp_we(adp_we), .h2s_rd(h2s_rd), .s2h_ld(s2h_ld),
    .bank_ld(bank_ld)
  );

  snd_mailbox #(.DATA_W(DATA_W)) u_mbox (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .cpu_ld(s2h_ld), .cpu_wdata(cpu_wdata), .h2s_q(h2s_q), .s2h_q(host_rdata)
  );

  assign smp_vec[0]    = adp_smp0;
  assign smp_vec[1]    = adp_smp1;
  assign adp_rd_vec[0] = adp_rdata0;
  assign adp_rd_vec[1] = adp_rdata1;

  for (genvar g = 0; g < NUM_ADP; g++) begin : g_adp
    snd_bank_map #(.DATA_W(DATA_W), .SMP_AW(SMP_AW)) u_bank (
      .clk(clk), .rst_n(rst_n), .ld(bank_ld[g]), .wdata(cpu_wdata),
      .smp_addr(smp_vec[g]), .raw_q(raw_vec[g]), .rom_addr(rom_vec[g])
    );
  end

  assign adp_rom0  = rom_vec[0];
  assign adp_rom1  = rom_vec[1];
  assign bank_raw0 = raw_vec[0];
  assign bank_raw1 = raw_vec[1];

  // Read-data return: only the selected source drives the bus, otherwise 0.
  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      if (rom_cs)         cpu_rdata = rom_rdata;
      else if (ram_cs)    cpu_rdata = ram_rdata;
      else if (fm_cs)     cpu_rdata = fm_rdata;
      else if (h2s_rd)    cpu_rdata = h2s_q;
      else begin
        for (int i = 0; i < NUM_ADP; i++)
          if (adp_cs[i]) cpu_rdata = adp_rd_vec[i];
      end
    end
  end

  // The host control bit is active low: the inverse of the captured bit is held as the NMI level.
  always_ff @(posedge clk) begin
    if (!rst_n)           nmi_q <= 1'b0;
    else if (host_nmi_wr) nmi_q <= ~host_nmi_bit;
  end

  assign cpu_nmi = nmi_q;
  assign cpu_irq = fm_irq;

  p_nmi_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_nmi_wr |=> (cpu_nmi != $past(host_nmi_bit)));

  p_nmi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !host_nmi_wr |=> $stable(cpu_nmi));

  p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && region == RG_NONE) |-> (cpu_rdata == '0));

  p_mailbox_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    h2s_rd |-> (cpu_rdata == h2s_q));

endmodule

// File: tb/snd_glue_top_tb.sv
module snd_glue_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        rom_cs, ram_cs, ram_we, fm_cs, fm_we, fm_a0, adp_we;
  logic [11:0] ram_addr;
  logic [1:0]  adp_cs;
  logic        fm_irq = 1'b0;
  logic [17:0] adp_smp0 = '0, adp_smp1 = '0;
  logic [19:0] adp_rom0, adp_rom1;
  logic [7:0]  bank_raw0, bank_raw1, host_rdata;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        host_nmi_wr = 1'b0, host_nmi_bit = 1'b1;
  logic        cpu_nmi, cpu_irq;

  localparam logic [7:0] ROM_D = 8'hA1, RAM_D = 8'hB2, FM_D = 8'hC3,
                         AD0_D = 8'hD4, AD1_D = 8'hE5;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  snd_glue_top u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rom_cs(rom_cs), .rom_rdata(ROM_D),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr), .ram_rdata(RAM_D),
    .fm_cs(fm_cs), .fm_we(fm_we), .fm_a0(fm_a0), .fm_rdata(FM_D), .fm_irq(fm_irq),
    .adp_cs(adp_cs), .adp_we(adp_we), .adp_rdata0(AD0_D), .adp_rdata1(AD1_D),
    .adp_smp0(adp_smp0), .adp_smp1(adp_smp1), .adp_rom0(adp_rom0), .adp_rom1(adp_rom1),
    .bank_raw0(bank_raw0), .bank_raw1(bank_raw1), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_nmi_wr(host_nmi_wr),
    .host_nmi_bit(host_nmi_bit), .cpu_nmi(cpu_nmi), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_map(input logic [17:0] a, input logic [7:0] raw);
    int page;
    if (a < 18'h20000) return {2'b00, a};
    page = (int'(raw) + 1) % 4;
    return 20'(32'h20000 + page * 32'h20000 + (int'(a) - 32'h20000));
  endfunction

  function automatic logic [5:0] sel_vec();
    return {rom_cs, ram_cs, fm_cs, adp_cs, ram_we};
  endfunction

  task automatic cpu_read(input logic [15:0] a);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0; #2;
  endtask

  task automatic bus_idle();
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_rd = 1'b0; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0; #2;
  endtask

  task automatic t_reset();
    chk("R10 host latch", host_rdata, 0);
    chk("R10 bank0", bank_raw0, 0);
    chk("R10 bank1", bank_raw1, 0);
    chk("R10 nmi", cpu_nmi, 0);
    adp_smp0 = 18'h20000; #1;
    chk("R10 default page", adp_rom0, 20'h40000);
    cpu_read(16'hFB00);
    chk("R10 h2s cleared", cpu_rdata, 0);
    bus_idle();
  endtask

  task automatic t_rom();
    cpu_read(16'h0000);
    chk("R1 rom_cs low", rom_cs, 1); chk("R1 rdata low", cpu_rdata, ROM_D);
    cpu_read(16'hEFFF);
    chk("R1 rom_cs top", rom_cs, 1); chk("R1 rdata top", cpu_rdata, ROM_D);
    bus_idle();
    @(negedge clk); cpu_addr = 16'h1234; cpu_wr = 1'b1; #2;
    chk("R1 rom write no select", {rom_cs, ram_cs, fm_cs, adp_cs}, 0);
    bus_idle();
  endtask

  task automatic t_ram();
    cpu_read(16'hF000);
    chk("R2 ram_cs", ram_cs, 1); chk("R2 addr F000", ram_addr, 12'h000);
    chk("R2 rdata", cpu_rdata, RAM_D); chk("R2 rom off", rom_cs, 0);
    cpu_read(16'hF7FF); chk("R2 addr F7FF", ram_addr, 12'h7FF);
    cpu_read(16'hFEC0); chk("R3 addr FEC0", ram_addr, 12'h800);
    cpu_read(16'hFFBF); chk("R3 addr FFBF", ram_addr, 12'h8FF);
    chk("R3 rdata", cpu_rdata, RAM_D);
    cpu_read(16'hFFC0);
    chk("R3 FFC0 outside", ram_cs, 0); chk("R13 FFC0 reads 0", cpu_rdata, 0);
    cpu_read(16'hF800); cpu_read(16'hFEBF);
    chk("R13 FEBF unmapped", sel_vec(), 0);
    bus_idle();
    @(negedge clk); cpu_addr = 16'hF005; cpu_wr = 1'b1; #2;
    chk("R2 write we", {ram_cs, ram_we}, 2'b11); chk("R2 write addr", ram_addr, 12'h005);
    bus_idle();
  endtask

  task automatic t_fm();
    cpu_read(16'hF800);
    chk("R4 fm_cs", fm_cs, 1); chk("R4 a0=0", fm_a0, 0); chk("R4 rdata", cpu_rdata, FM_D);
    cpu_read(16'hF801); chk("R4 a0=1", fm_a0, 1);
    bus_idle();
    @(negedge clk); cpu_addr = 16'hF801; cpu_wr = 1'b1; #2;
    chk("R4 write", {fm_cs, fm_we, fm_a0}, 3'b111);
    bus_idle();
  endtask

  task automatic t_adp();
    cpu_read(16'hF900); chk("R5 cs0", adp_cs, 2'b01); chk("R5 rd0", cpu_rdata, AD0_D);
    cpu_read(16'hFA00); chk("R5 cs1", adp_cs, 2'b10); chk("R5 rd1", cpu_rdata, AD1_D);
    bus_idle();
    @(negedge clk); cpu_addr = 16'hFA00; cpu_wr = 1'b1; #2;
    chk("R5 write", {adp_cs, adp_we}, 3'b101);
    bus_idle();
  endtask

  task automatic t_mbox();
    @(negedge clk); host_wdata = 8'h5A; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    cpu_read(16'hFB00); chk("R6 h2s read", cpu_rdata, 8'h5A);
    bus_idle();
    cpu_write(16'hFC00, 8'hA5);
    chk("R7 s2h", host_rdata, 8'hA5);
    cpu_write(16'hFB00, 8'h11);
    cpu_read(16'hFB00); chk("R13 FB00 not writable", cpu_rdata, 8'h5A);
    bus_idle();
  endtask

  task automatic t_bank();
    cpu_write(16'hFC01, 8'h02);
    cpu_write(16'hFC02, 8'h03);
    chk("R8 raw0", bank_raw0, 8'h02); chk("R8 raw1", bank_raw1, 8'h03);
    adp_smp0 = 18'h20000; adp_smp1 = 18'h3FFFF; #1;
    chk("R9 chip0 page", adp_rom0, exp_map(18'h20000, 8'h02));
    chk("R9 chip1 wrap", adp_rom1, exp_map(18'h3FFFF, 8'h03));
    adp_smp0 = 18'h1ABCD; #1;
    chk("R9 low half", adp_rom0, 20'h1ABCD);
    cpu_write(16'hFC01, 8'hFF);
    adp_smp0 = 18'h2ABCD; #1;
    chk("R8 raw FF", bank_raw0, 8'hFF);
    chk("R9 FF wraps", adp_rom0, exp_map(18'h2ABCD, 8'hFF));
  endtask

  task automatic t_unmapped();
    cpu_write(16'hFC03, 8'h77);
    cpu_write(16'h2000, 8'h66);
    chk("R13 bank0 kept", bank_raw0, 8'hFF);
    chk("R13 bank1 kept", bank_raw1, 8'h03);
    chk("R13 s2h kept", host_rdata, 8'hA5);
    cpu_read(16'hFD00);
    chk("R13 read 0", cpu_rdata, 0); chk("R13 no select", sel_vec(), 0);
    bus_idle();
  endtask

  task automatic t_irq_nmi();
    fm_irq = 1'b1; #1; chk("R12 irq high", cpu_irq, 1);
    fm_irq = 1'b0; #1; chk("R12 irq low", cpu_irq, 0);
    @(negedge clk); host_nmi_bit = 1'b0; host_nmi_wr = 1'b1;
    @(negedge clk); host_nmi_wr = 1'b0; host_nmi_bit = 1'b1; #2;
    chk("R11 nmi asserted", cpu_nmi, 1);
    @(negedge clk); #2; chk("R11 nmi held", cpu_nmi, 1);
    @(negedge clk); host_nmi_wr = 1'b1;
    @(negedge clk); host_nmi_wr = 1'b0; #2;
    chk("R11 nmi released", cpu_nmi, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2; t_reset_pre();
  end

  task automatic t_reset_pre();
    rst_n = 1'b1;
    @(negedge clk); #2;
    t_reset();
    t_rom();
    t_ram();
    t_fm();
    t_adp();
    t_mbox();
    t_bank();
    t_unmapped();
    t_irq_nmi();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule